// File: doc/BRIEF.md
# Interrupt Aggregator with NMI Routing

This block gathers thirty-two peripheral interrupt request lines, brings each into the core clock domain through a flop synchronizer, and merges it with a software-controlled request bit. The result drives a 32-bit interrupt vector toward the processor. One position of that vector can also be steered onto a single non-maskable interrupt (NMI) line. The enable for that path only changes after software has written a three-byte key sequence to a protection register.

Software reaches the block through a command/response register port with valid/ready handshakes on both channels. Each accepted command, read or write, returns exactly one response beat. The response holds its data until `rsp_ready` is seen. While a response is still waiting, `cmd_ready` stays low, so the port never holds more than one transaction at a time. The software request register works as a bitwise toggle: writing 1 to a bit flips it and writing 0 leaves it unchanged. Setting a bit therefore raises that line, and writing 1 again drops it. Per-position identity registers give a 3-bit summary of what is driving each line.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, `irq_out` and `nmi_out` are 0 and every mapped register reads 0.
- R2: A level on `irq_in[n]` appears on `irq_out[n]` at the second rising clock edge after it is presented, and not earlier. `irq_out[n]` is the OR of the synchronized line and software bit n.
- R3: The software request register at offset 0x84 reads back its 32-bit value. Writing 1 to bit n inverts bit n, so a 0 becomes 1 and a 1 becomes 0. Writing 0 to a bit leaves it unchanged. The new value drives `irq_out` from the edge that accepts the write.
- R4: The routing register at offset 0x80 holds a 5-bit source index in bits 4:0, which any write can change. It holds the NMI enable in bit 8, where 1 means enabled. It reads back as {23'b0, enable, 3'b0, index}.
- R5: While the protection state is locked, a write to offset 0x80 leaves bit 8 unchanged.
- R6: Writing the low bytes 0x59, 0x16 and 0x88, in that order, to offset 0x100 unlocks the protection state. Reading offset 0x100 returns 1 while unlocked and 0 otherwise.
- R7: A byte that breaks the key sequence sends it back to the start, except that 0x59 always counts as the first key byte. Any write to offset 0x100 while unlocked locks it again.
- R8: `nmi_out` equals `irq_out[index]` ANDed with the enable bit.
- R9: The identity register for position n sits at offset 4*n, for n from 0 to 31. Bit 0 is the synchronized line n, bit 1 is software bit n, and bit 2 is set when n is the routed index with the enable set. Upper bits read 0, and writes to these registers are ignored.
- R10: Reads from unmapped or non-word-aligned offsets return 0, and writes to them change no state.
- R11: Every accepted command yields one response, in order. While `rsp_valid` is high and `rsp_ready` low, `rsp_rdata` stays stable and `cmd_ready` is low. Write responses carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Peripheral interrupt request levels (asynchronous) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 12 | Byte offset |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_out | output | 32 | Interrupt vector to the core |
| nmi_out | output | 1 | Non-maskable interrupt to the core |

## Verification
The bench builds the block with its defaults: 32 positions, two synchronizer stages and a 12-bit offset space. With these values the full 5-bit routing index, the protection register at 0x100 and the unmapped space above it are all reachable. The two-edge synchronizer delay can also be sampled edge by edge. The bench applies response back-pressure in a stretch of the run, which exercises the stall path of the port and the one-transaction limit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [7:0] KEY_A = 8'h59;
  localparam logic [7:0] KEY_B = 8'h16;
  localparam logic [7:0] KEY_C = 8'h88;
  localparam int unsigned OFS_ROUTE = 'h80;
  localparam int unsigned OFS_SOFT  = 'h84;
  localparam int unsigned OFS_GUARD = 'h100;
  localparam int unsigned EN_BIT    = 8;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_KEY1 = 2'd1,
    GS_KEY2 = 2'd2,
    GS_OPEN = 2'd3
  } guard_st_e;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_soft_reg.sv
module irq_soft_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 q[b] <= 1'b0;
        else if (we && wdata[b])    q[b] <= ~q[b];
      end
    end
  endgenerate

  // R3: bits written with 0 keep their value across a write
  p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  // R3: without a write the register holds
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/irq_guard_fsm.sv
module irq_guard_fsm
  import irq_agg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  output logic       unlocked
);
  guard_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr) begin
      unique case (st_q)
        GS_IDLE: st_d = (wbyte == KEY_A) ? GS_KEY1 : GS_IDLE;
        GS_KEY1: st_d = (wbyte == KEY_B) ? GS_KEY2 :
                        (wbyte == KEY_A) ? GS_KEY1 : GS_IDLE;
        GS_KEY2: st_d = (wbyte == KEY_C) ? GS_OPEN :
                        (wbyte == KEY_A) ? GS_KEY1 : GS_IDLE;
        GS_OPEN: st_d = (wbyte == KEY_A) ? GS_KEY1 : GS_IDLE;
        default: st_d = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == GS_OPEN);

  // R6: opening only follows a write of the final key byte
  p_open_on_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr && (wbyte == KEY_C)));
  // R7: any guard write while open closes it
  p_write_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr) |=> !unlocked);
endmodule

// File: rtl/irq_nmi_route.sv
module irq_nmi_route #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic [WIDTH-1:0] irq_vec,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q,
  output logic             nmi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (en_we)  en_q  <= en_wdata;
    end
  end

  assign nmi = en_q & irq_vec[sel_q];
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [BUS_W-1:0]   cmd_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BUS_W-1:0]   rsp_rdata,
  output logic [NUM_IRQ-1:0] irq_out,
  output logic               nmi_out
);
  localparam int unsigned SEL_W  = $clog2(NUM_IRQ);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_ROUTE = WORD_W'(OFS_ROUTE / 4);
  localparam logic [WORD_W-1:0] W_SOFT  = WORD_W'(OFS_SOFT / 4);
  localparam logic [WORD_W-1:0] W_GUARD = WORD_W'(OFS_GUARD / 4);
  localparam logic [WORD_W-1:0] W_IDMAX = WORD_W'(NUM_IRQ);

  logic [NUM_IRQ-1:0] sync_vec, soft_vec;
  logic [SEL_W-1:0]   route_sel;
  logic               route_en, unlocked;
  logic               accept, wr_acc;
  logic [WORD_W-1:0]  word;
  logic               aligned, hit_id, hit_route, hit_soft, hit_guard;
  logic [SEL_W-1:0]   id_idx;
  logic [BUS_W-1:0]   rd_data;
  logic               rsp_valid_q;
  logic [BUS_W-1:0]   rsp_rdata_q;

  // Port handshake: one transaction outstanding at most
  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign wr_acc    = accept && cmd_write;

  // Address decode
  assign aligned   = (cmd_addr[1:0] == 2'b00);
  assign word      = cmd_addr[ADDR_W-1:2];
  assign hit_id    = aligned && (word < W_IDMAX);
  assign hit_route = aligned && (word == W_ROUTE);
  assign hit_soft  = aligned && (word == W_SOFT);
  assign hit_guard = aligned && (word == W_GUARD);
  assign id_idx    = word[SEL_W-1:0];

  irq_sync_bank #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_vec)
  );

  irq_soft_reg #(.WIDTH(NUM_IRQ)) u_soft (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_acc && hit_soft),
    .wdata (cmd_wdata[NUM_IRQ-1:0]),
    .q     (soft_vec)
  );

  irq_guard_fsm u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_acc && hit_guard),
    .wbyte    (cmd_wdata[7:0]),
    .unlocked (unlocked)
  );

  assign irq_out = sync_vec | soft_vec;

  irq_nmi_route #(.WIDTH(NUM_IRQ), .SEL_W(SEL_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (wr_acc && hit_route),
    .sel_wdata (cmd_wdata[SEL_W-1:0]),
    .en_we     (wr_acc && hit_route && unlocked),
    .en_wdata  (cmd_wdata[EN_BIT]),
    .irq_vec   (irq_out),
    .sel_q     (route_sel),
    .en_q      (route_en),
    .nmi       (nmi_out)
  );

  // Read mux
  always_comb begin
    rd_data = '0;
    if (hit_id) begin
      rd_data[0] = sync_vec[id_idx];
      rd_data[1] = soft_vec[id_idx];
      rd_data[2] = route_en && (route_sel == id_idx);
    end else if (hit_route) begin
      rd_data[SEL_W-1:0] = route_sel;
      rd_data[EN_BIT]    = route_en;
    end else if (hit_soft) begin
      rd_data[NUM_IRQ-1:0] = soft_vec;
    end else if (hit_guard) begin
      rd_data[0] = unlocked;
    end
  end

  // Response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= cmd_write ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11: a stalled response keeps its beat
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R5: the enable only moves after a write made while open
  p_en_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en != $past(route_en)) |-> $past(unlocked && wr_acc && hit_route));
  // R8: the NMI follows the routed vector bit under the enable
  p_nmi_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out == (route_en && irq_out[route_sel]));
  // R10: writes that miss the software register leave it alone
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !hit_soft) |=> $stable(soft_vec));
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/100ps
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] irq_out;
  logic        nmi_out;

  int tests = 0;
  int fails = 0;
  bit bp_on = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          stalled = 0;
  logic [31:0] stall_data = '0;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: sets back-pressure, pops the scoreboard on each transfer
  always @(negedge clk) begin
    cyc++;
    rsp_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    #0.2;
    if (stalled) begin
      chk("R11 stall valid", {31'b0, rsp_valid}, 32'd1);
      chk("R11 stall data", rsp_rdata, stall_data);
    end
    stalled = rsp_valid && !rsp_ready;
    stall_data = rsp_rdata;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R11 extra response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  // Driver: one command, expected response pushed to the scoreboard
  task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] e, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    forever begin
      #0.5;
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #0.1 cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    bus(1'b1, a, d, 32'd0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus(1'b0, a, 32'd0, e, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1: reset state
    chk("R1 irq_out", irq_out, 32'd0);
    chk("R1 nmi_out", {31'b0, nmi_out}, 32'd0);
    rd(12'h084, 32'd0, "R1 soft read");
    rd(12'h080, 32'd0, "R1 route read");
    rd(12'h100, 32'd0, "R1 guard read");
    rd(12'h000, 32'd0, "R1 id0 read");

    // R3: toggle semantics
    wr(12'h084, 32'h0000_00F0, "R3 set wr");
    drain(); chk("R3 irq set", irq_out, 32'h0000_00F0);
    wr(12'h084, 32'h0000_0030, "R3 clr wr");
    rd(12'h084, 32'h0000_00C0, "R3 clear read");
    wr(12'h084, 32'h0000_0000, "R3 zero wr");
    rd(12'h084, 32'h0000_00C0, "R3 zero no effect");
    wr(12'h084, 32'h0000_0003, "R3 set2 wr");
    drain(); chk("R3 irq vec", irq_out, 32'h0000_00C3);

    // R2: synchronizer latency
    @(negedge clk); irq_in = 32'h0001_0000;
    @(negedge clk); #0.5; chk("R2 after one edge", irq_out, 32'h0000_00C3);
    @(negedge clk); #0.5; chk("R2 after two edges", irq_out, 32'h0001_00C3);

    // R9: identity registers
    rd(12'h040, 32'd1, "R9 id16 sync");
    rd(12'h01C, 32'd2, "R9 id7 soft");
    wr(12'h040, 32'h7, "R9 id wr");
    rd(12'h040, 32'd1, "R9 id write ignored");

    // R4/R5: locked enable
    wr(12'h080, 32'h0000_0110, "R5 locked wr");
    rd(12'h080, 32'h0000_0010, "R5 enable kept 0");
    drain(); chk("R8 nmi off", {31'b0, nmi_out}, 32'd0);

    // R7: broken sequence, then 0x59 restart
    wr(12'h100, 32'h59, "R7 k1"); wr(12'h100, 32'h16, "R7 k2");
    wr(12'h100, 32'h77, "R7 bad");
    rd(12'h100, 32'd0, "R7 locked after bad byte");
    wr(12'h100, 32'h59, "R7 a"); wr(12'h100, 32'h59, "R7 restart");
    wr(12'h100, 32'h16, "R6 k2"); wr(12'h100, 32'h88, "R6 k3");
    rd(12'h100, 32'd1, "R6 unlocked");
    wr(12'h080, 32'h0000_0110, "R4 open wr");
    rd(12'h080, 32'h0000_0110, "R4 route read");
    drain(); chk("R8 nmi on", {31'b0, nmi_out}, 32'd1);
    rd(12'h040, 32'd5, "R9 id16 routed");

    // R7: relock, index still writable, enable kept
    wr(12'h100, 32'h00, "R7 relock wr");
    rd(12'h100, 32'd0, "R7 relocked");
    wr(12'h080, 32'h0000_0005, "R4 index wr");
    rd(12'h080, 32'h0000_0105, "R4 index changed en kept");
    drain(); chk("R8 nmi idx5 low", {31'b0, nmi_out}, 32'd0);
    wr(12'h084, 32'h0000_0020, "R8 soft5 wr");
    drain(); chk("R8 nmi idx5 high", {31'b0, nmi_out}, 32'd1);

    // R10: unmapped and misaligned
    rd(12'h088, 32'd0, "R10 unmapped read");
    rd(12'h200, 32'd0, "R10 high read");
    rd(12'h082, 32'd0, "R10 misaligned read");
    wr(12'h088, 32'hFFFF_FFFF, "R10 unmapped wr");
    wr(12'h086, 32'hFFFF_FFFF, "R10 misaligned wr");
    rd(12'h084, 32'h0000_00E3, "R10 soft unchanged");

    // R2: falling line
    @(negedge clk); irq_in = 32'h0;
    @(negedge clk); @(negedge clk); #0.5;
    chk("R2 line drop", irq_out, 32'h0000_00E3);

    // R11: back-pressure
    bp_on = 1;
    for (int i = 0; i < 6; i++) begin
      rd(12'h084, 32'h0000_00E3, "R11 bp read");
      wr(12'h0C0, 32'h1, "R11 bp write");
    end
    rd(12'h080, 32'h0000_0105, "R11 bp route");
    drain();
    bp_on = 0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule